// File: doc/BRIEF.md
# BLAKE2s Block Compression Core

This core computes the BLAKE2s compression function over one 64-byte message block at a time. A caller supplies the 256-bit chaining value, the block, the current 64-bit byte counter, the byte increment for this block and the two finalization words. The core adds the increment to the counter first. It then builds the sixteen-word working state and runs ten rounds of column and diagonal mixing. Each mixing step takes its two message words from a fixed per-round schedule. Finally, the core folds the working state back into the chaining value.

Blocks enter through a valid/ready handshake. Results leave through a second valid/ready handshake that carries the new chaining value and the updated counter. The caller feeds both back with the next block to hash a stream. Every block after the first uses an increment of 64. The engine evaluates one mixing group per clock. It holds off further input until its result has been taken. Padding, keying, parameter-block setup and digest truncation stay with the caller.

Top module: `blake2s_core`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `busy` is 0.
- R2: A block is taken on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle until the result is taken, `busy` is 1 and `in_ready` is 0. Any `in_valid` or input data offered in that time has no effect on the result.
- R3: `out_t` equals `in_t + in_inc` as a 64-bit sum, with the carry running from the low word (bits 31:0) into the high word (bits 63:32). The sum is taken before mixing.
- R4: The working state is set up as follows. Words 0..7 come from the chaining value. Words 8..15 come from the eight IV constants 6A09E667, BB67AE85, 3C6EF372, A54FF53A, 510E527F, 9B05688C, 1F83D9AB, 5BE0CD19. Word 12 is XORed with the low counter word and word 13 with the high counter word. Word 14 is XORed with `in_f[31:0]` and word 15 with `in_f[63:32]`.
- R5: Exactly ten rounds are run. Each round first mixes the columns (0,4,8,12)…(3,7,11,15) and then the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14). Group g of a round uses the message words at schedule positions 2g and 2g+1 of that round's fixed permutation, so every round uses each of the sixteen words exactly once.
- R6: One mixing group performs four add/xor/rotate stages with right-rotations of 16, 12, 8 and 7 bits. All additions are taken modulo 2^32.
- R7: The new chaining word i is the old word i XORed with working words i and i+8, for i = 0..7.
- R8: Word j of `in_msg`, `in_h` and `out_h` occupies bits 32j+31:32j. Byte k of the block sits at bits 8k+7:8k, so byte 4j is the least significant byte of message word j.
- R9: One group is mixed per cycle. `out_valid` first rises in the 81st cycle after the accepting edge (80 mixing cycles plus one fold cycle).
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_h` and `out_t` hold. After the output handshake edge, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Block offered |
| in_ready | output | 1 | Core idle and able to take a block |
| in_h | input | 256 | Chaining value, word j at bits 32j+31:32j |
| in_msg | input | 512 | Message block, byte k at bits 8k+7:8k |
| in_t | input | 64 | Byte counter before this block |
| in_inc | input | 32 | Bytes added to the counter for this block |
| in_f | input | 64 | Finalization words, f0 in bits 31:0 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Caller takes the result |
| out_h | output | 256 | Updated chaining value |
| out_t | output | 64 | Updated counter |
| busy | output | 1 | A block is in progress or its result is unclaimed |

## Verification
The embedded properties check the following on every cycle:
- a taken block raises `busy` and drops `in_ready`;
- the result appears exactly 81 cycles after acceptance;
- a stalled result does not move;
- every round draws each message word exactly once.

The arithmetic itself can only be shown by the bench scenarios. These compare the state setup, the rotations, the schedule contents and the fold against a known digest and an independent model. The same applies to the counter carry across the word boundary, chained blocks, and input ignored while busy.

// File: rtl/blake2s_pkg.sv
// Shared constants, types and helpers for the BLAKE2s compression core.
// Assumes 32-bit words, a 16-word working state and an 8-word chaining value.
package blake2s_pkg;
    localparam int WORD_W   = 32;
    localparam int NWORDS   = 16;
    localparam int HWORDS   = 8;
    localparam int GROUPS   = 8;
    localparam int SCHED_N  = 10;
    localparam int IDX_W    = $clog2(NWORDS);
    localparam int GRP_W    = $clog2(GROUPS);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MIX,
        ST_FOLD,
        ST_DONE
    } core_st_t;

    // Right-rotate a word by n bits.
    function automatic word_t rotr(input word_t v, input int unsigned n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    // Initialization constant i of the working state's lower half.
    function automatic word_t iv_word(input logic [2:0] i);
        case (i)
            3'd0:    return 32'h6A09E667;
            3'd1:    return 32'hBB67AE85;
            3'd2:    return 32'h3C6EF372;
            3'd3:    return 32'hA54FF53A;
            3'd4:    return 32'h510E527F;
            3'd5:    return 32'h9B05688C;
            3'd6:    return 32'h1F83D9AB;
            default: return 32'h5BE0CD19;
        endcase
    endfunction

    // Message word used at position p of schedule row r (nibble p of the row).
    function automatic logic [IDX_W-1:0] sched_nib(input logic [3:0] r, input logic [3:0] p);
        logic [63:0] row;
        case (r)
            4'd1:    row = 64'h357B20C16DF984AE;
            4'd2:    row = 64'h491763EADF250C8B;
            4'd3:    row = 64'h8F04A562EBCD1397;
            4'd4:    row = 64'hD386CB1EFA427509;
            4'd5:    row = 64'h91EF57D438B0A6C2;
            4'd6:    row = 64'hB8293670A4DEF15C;
            4'd7:    row = 64'hA2684F05931CE7BD;
            4'd8:    row = 64'h5A417D2C803B9EF6;
            4'd9:    row = 64'h0DC3E9BF5167482A;
            default: row = 64'hFEDCBA9876543210;
        endcase
        return row[{p, 2'b00} +: 4];
    endfunction

    // State index of lane (a=0,b=1,c=2,d=3) in group g; groups 4..7 walk diagonals.
    function automatic logic [IDX_W-1:0] lane_idx(input logic [GRP_W-1:0] g, input logic [1:0] lane);
        logic [1:0] col;
        col = g[2] ? (g[1:0] + lane) : g[1:0];
        return {lane, col};
    endfunction
endpackage

// File: rtl/blake2s_gmix.sv
// One BLAKE2s mixing group: combinational add/xor/rotate over four state words
// and two message words. Assumes the caller registers the result.
module blake2s_gmix
    import blake2s_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    input  word_t x_i,
    input  word_t y_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);
    word_t a1, b1, c1, d1;

    // Two half-steps: first with x and rotations 16/12, then with y and 8/7.
    always_comb begin
        a1  = a_i + b_i + x_i;
        d1  = rotr(d_i ^ a1, 16);
        c1  = c_i + d1;
        b1  = rotr(b_i ^ c1, 12);
        a_o = a1 + b1 + y_i;
        d_o = rotr(d1 ^ a_o, 8);
        c_o = c1 + d_o;
        b_o = rotr(b1 ^ c_o, 7);
    end
endmodule

// File: rtl/blake2s_sched.sv
// Round and group sequencer. Steps through GROUPS groups per round for ROUNDS
// rounds and selects the two message-word indices for the current group.
// Assumes clear is pulsed when a block is accepted.
module blake2s_sched
    import blake2s_pkg::*;
#(
    parameter int ROUNDS = 10,
    localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [GRP_W-1:0] grp_o,
    output logic [IDX_W-1:0] xsel_o,
    output logic [IDX_W-1:0] ysel_o,
    output logic             last_o
);
    logic [GRP_W-1:0] grp_q;
    logic [RW-1:0]    rnd_q;
    logic [3:0]       row_q;

    // Advance group, round and wrapping schedule row on each mixing step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            grp_q <= '0;
            rnd_q <= '0;
            row_q <= '0;
        end else if (step) begin
            grp_q <= grp_q + 1'b1;
            if (grp_q == GRP_W'(GROUPS - 1)) begin
                rnd_q <= rnd_q + 1'b1;
                row_q <= (row_q == 4'(SCHED_N - 1)) ? 4'd0 : row_q + 4'd1;
            end
        end
    end

    // Word selection for the two halves of the current group.
    always_comb begin
        grp_o  = grp_q;
        xsel_o = sched_nib(row_q, {grp_q, 1'b0});
        ysel_o = sched_nib(row_q, {grp_q, 1'b1});
        last_o = (grp_q == GRP_W'(GROUPS - 1)) && (rnd_q == RW'(ROUNDS - 1));
    end

    // Words drawn so far in this round (assertion support).
    logic [NWORDS-1:0] seen_q;
    logic [NWORDS-1:0] xbit, ybit;
    assign xbit = NWORDS'(1) << xsel_o;
    assign ybit = NWORDS'(1) << ysel_o;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            seen_q <= '0;
        else if (step)
            seen_q <= (grp_q == GRP_W'(GROUPS - 1)) ? '0 : (seen_q | xbit | ybit);
    end

    // R5: each round consumes all sixteen message words exactly once.
    a_r5_round_uses_all_words: assert property (@(posedge clk) disable iff (!rst_n)
        (step && grp_q == GRP_W'(GROUPS - 1)) |-> ((seen_q | xbit | ybit) == '1));
endmodule

// File: rtl/blake2s_core.sv
// BLAKE2s compression core. Takes one block with chaining value, counter,
// increment and finalization words, mixes one group per cycle for ROUNDS
// rounds, folds into the chaining value and holds the result until taken.
// Assumes the caller chains out_h/out_t back in for multi-block messages.
module blake2s_core
    import blake2s_pkg::*;
#(
    parameter int ROUNDS = 10
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [HWORDS*WORD_W-1:0]   in_h,
    input  logic [NWORDS*WORD_W-1:0]   in_msg,
    input  logic [2*WORD_W-1:0]        in_t,
    input  logic [WORD_W-1:0]          in_inc,
    input  logic [2*WORD_W-1:0]        in_f,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [HWORDS*WORD_W-1:0]   out_h,
    output logic [2*WORD_W-1:0]        out_t,
    output logic                       busy
);
    localparam int LATENCY = ROUNDS * GROUPS + 1;
    localparam int LCW     = $clog2(LATENCY + 1) + 1;

    core_st_t                        st_q;
    logic [NWORDS-1:0][WORD_W-1:0]   v_q, v_init, v_mix;
    logic [NWORDS-1:0][WORD_W-1:0]   m_q;
    logic [HWORDS-1:0][WORD_W-1:0]   h_q, h_fold, h_in_w;
    logic [2*WORD_W-1:0]             t_q, t_next;
    logic                            accept, last;
    logic [GRP_W-1:0]                grp;
    logic [IDX_W-1:0]                xsel, ysel;
    logic [IDX_W-1:0]                ia, ib, ic, id;
    word_t                           na, nb, nc, nd;

    assign accept   = in_valid && (st_q == ST_IDLE);
    assign in_ready = (st_q == ST_IDLE);
    assign busy     = (st_q != ST_IDLE);
    assign out_valid = (st_q == ST_DONE);
    assign out_h    = h_q;
    assign out_t    = t_q;
    assign h_in_w   = in_h;
    assign t_next   = in_t + {{WORD_W{1'b0}}, in_inc};

    // Group sequencer and message schedule.
    blake2s_sched #(.ROUNDS(ROUNDS)) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .step   (st_q == ST_MIX),
        .grp_o  (grp),
        .xsel_o (xsel),
        .ysel_o (ysel),
        .last_o (last)
    );

    // Working state seeded from chaining value, IV, counter and finalization words.
    always_comb begin
        for (int i = 0; i < HWORDS; i++) begin
            v_init[i]          = h_in_w[i];
            v_init[HWORDS + i] = iv_word(3'(i));
        end
        v_init[HWORDS + 4] = v_init[HWORDS + 4] ^ t_next[WORD_W-1:0];
        v_init[HWORDS + 5] = v_init[HWORDS + 5] ^ t_next[2*WORD_W-1:WORD_W];
        v_init[HWORDS + 6] = v_init[HWORDS + 6] ^ in_f[WORD_W-1:0];
        v_init[HWORDS + 7] = v_init[HWORDS + 7] ^ in_f[2*WORD_W-1:WORD_W];
    end

    // Lane indices of the current column or diagonal.
    always_comb begin
        ia = lane_idx(grp, 2'd0);
        ib = lane_idx(grp, 2'd1);
        ic = lane_idx(grp, 2'd2);
        id = lane_idx(grp, 2'd3);
    end

    blake2s_gmix u_gmix (
        .a_i (v_q[ia]),
        .b_i (v_q[ib]),
        .c_i (v_q[ic]),
        .d_i (v_q[id]),
        .x_i (m_q[xsel]),
        .y_i (m_q[ysel]),
        .a_o (na),
        .b_o (nb),
        .c_o (nc),
        .d_o (nd)
    );

    // Write the mixed lanes back into a copy of the state.
    always_comb begin
        v_mix     = v_q;
        v_mix[ia] = na;
        v_mix[ib] = nb;
        v_mix[ic] = nc;
        v_mix[id] = nd;
    end

    // Fold both halves of the working state into the chaining value.
    generate
        for (genvar i = 0; i < HWORDS; i++) begin : g_fold
            assign h_fold[i] = h_q[i] ^ v_q[i] ^ v_q[HWORDS + i];
        end
    endgenerate

    // Control sequence: idle, mix, fold, hold result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (in_valid)  st_q <= ST_MIX;
                ST_MIX:  if (last)      st_q <= ST_FOLD;
                ST_FOLD:                st_q <= ST_DONE;
                default: if (out_ready) st_q <= ST_IDLE;
            endcase
        end
    end

    // Datapath registers: capture on accept, mix per group, fold once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            m_q <= '0;
            h_q <= '0;
            t_q <= '0;
        end else if (accept) begin
            v_q <= v_init;
            m_q <= in_msg;
            h_q <= h_in_w;
            t_q <= t_next;
        end else if (st_q == ST_MIX) begin
            v_q <= v_mix;
        end else if (st_q == ST_FOLD) begin
            h_q <= h_fold;
        end
    end

    // Cycles since acceptance, counted through mixing and folding (assertion support).
    logic [LCW-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (accept)
            lat_q <= '0;
        else if (st_q == ST_MIX || st_q == ST_FOLD)
            lat_q <= lat_q + 1'b1;
    end

    // R2: a taken block blocks further input.
    a_r2_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !in_ready && !out_valid));

    // R9: result appears a fixed number of cycles after acceptance.
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (lat_q == LCW'(LATENCY)));

    // R10: a stalled result holds still.
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_h) && $stable(out_t)));

    // R10: after the output handshake the core is idle again.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

// File: tb/blake2s_core_test.sv
// Scoreboard bench: the driver pushes model results at acceptance, the monitor
// pops and compares when a result appears.
module blake2s_core_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_h = '0;
    logic [511:0] in_msg = '0;
    logic [63:0]  in_t = '0;
    logic [31:0]  in_inc = '0;
    logic [63:0]  in_f = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [255:0] out_h;
    logic [63:0]  out_t;
    logic         busy;

    localparam int LAT = 81;

    int    n_chk = 0;
    int    n_bad = 0;
    longint cyc = 0;
    bit    finished = 1'b0;

    typedef struct {
        logic [255:0] h;
        logic [63:0]  t;
        longint       acc;
    } exp_t;
    exp_t exp_q[$];

    logic [255:0] last_h;
    logic [63:0]  last_t;

    blake2s_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_h(in_h), .in_msg(in_msg), .in_t(in_t), .in_inc(in_inc), .in_f(in_f),
        .out_valid(out_valid), .out_ready(out_ready), .out_h(out_h), .out_t(out_t),
        .busy(busy)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    localparam logic [31:0] IVT [8] = '{32'h6A09E667, 32'hBB67AE85, 32'h3C6EF372, 32'hA54FF53A,
                                        32'h510E527F, 32'h9B05688C, 32'h1F83D9AB, 32'h5BE0CD19};
    localparam int GA [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
    localparam int GB [8] = '{4, 5, 6, 7, 5, 6, 7, 4};
    localparam int GC [8] = '{8, 9, 10, 11, 10, 11, 8, 9};
    localparam int GD [8] = '{12, 13, 14, 15, 15, 12, 13, 14};

    function automatic logic [63:0] srow(input int r);
        case (r)
            1: return 64'h357B20C16DF984AE;
            2: return 64'h491763EADF250C8B;
            3: return 64'h8F04A562EBCD1397;
            4: return 64'hD386CB1EFA427509;
            5: return 64'h91EF57D438B0A6C2;
            6: return 64'hB8293670A4DEF15C;
            7: return 64'hA2684F05931CE7BD;
            8: return 64'h5A417D2C803B9EF6;
            9: return 64'h0DC3E9BF5167482A;
            default: return 64'hFEDCBA9876543210;
        endcase
    endfunction

    function automatic logic [31:0] rr(input logic [31:0] v, input int n);
        return (v >> n) | (v << (32 - n));
    endfunction

    // Reference compression: returns {t_new, h_new}.
    function automatic logic [319:0] model(input logic [255:0] h, input logic [511:0] m,
                                           input logic [63:0] t, input logic [31:0] inc,
                                           input logic [63:0] f);
        logic [31:0]  v [16];
        logic [31:0]  w [16];
        logic [63:0]  tn, row;
        logic [255:0] ho;
        int a, b, c, d;
        tn = t + {32'd0, inc};
        for (int i = 0; i < 16; i++) w[i] = m[32*i +: 32];
        for (int i = 0; i < 8; i++) begin
            v[i]     = h[32*i +: 32];
            v[i + 8] = IVT[i];
        end
        v[12] ^= tn[31:0];
        v[13] ^= tn[63:32];
        v[14] ^= f[31:0];
        v[15] ^= f[63:32];
        for (int r = 0; r < 10; r++) begin
            row = srow(r);
            for (int g = 0; g < 8; g++) begin
                a = GA[g]; b = GB[g]; c = GC[g]; d = GD[g];
                v[a] = v[a] + v[b] + w[row[8*g +: 4]];
                v[d] = rr(v[d] ^ v[a], 16);
                v[c] = v[c] + v[d];
                v[b] = rr(v[b] ^ v[c], 12);
                v[a] = v[a] + v[b] + w[row[8*g+4 +: 4]];
                v[d] = rr(v[d] ^ v[a], 8);
                v[c] = v[c] + v[d];
                v[b] = rr(v[b] ^ v[c], 7);
            end
        end
        for (int i = 0; i < 8; i++) ho[32*i +: 32] = h[32*i +: 32] ^ v[i] ^ v[i + 8];
        return {tn, ho};
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Driver: offer a block, push the model's result at acceptance.
    task automatic send(input logic [255:0] h, input logic [511:0] m, input logic [63:0] t,
                        input logic [31:0] inc, input logic [63:0] f);
        exp_t e;
        logic [319:0] r;
        @(negedge clk);
        in_h = h; in_msg = m; in_t = t; in_inc = inc; in_f = f; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        r = model(h, m, t, inc, f);
        e.h = r[255:0];
        e.t = r[319:256];
        e.acc = cyc + 1;
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each result on the cycle it first appears.
    initial begin
        bit prev = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && !prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected result", out_h, '0);
                end else begin
                    e = exp_q.pop_front();
                    last_h = out_h;
                    last_t = out_t;
                    // R4 R5 R6 R7 R8: digest equals reference
                    check(out_h === e.h, "R4 R5 R6 R7 R8 chaining value", out_h, e.h);
                    // R3: counter
                    check(out_t === e.t, "R3 counter", {192'd0, out_t}, {192'd0, e.t});
                    // R9: latency from accepting edge
                    check((cyc - e.acc) == LAT, "R9 latency", 256'(cyc - e.acc), 256'(LAT));
                end
            end
            prev = out_valid;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [511:0] mpat;
        logic [319:0] r1;
        logic [255:0] hold_h;
        bit ok;

        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(in_ready === 1'b1, "R1 in_ready", 256'(in_ready), 256'd1);
        check(out_valid === 1'b0, "R1 out_valid", 256'(out_valid), 256'd0);
        check(busy === 1'b0, "R1 busy", 256'(busy), 256'd0);

        // R4 R5 R6 R7 R8: single-block digest of the bytes "abc" with a 32-byte output parameter
        send(256'h5BE0CD19_1F83D9AB_9B05688C_510E527F_A54FF53A_3C6EF372_BB67AE85_6B08E647,
             {488'd0, 24'h636261}, 64'd0, 32'd3, 64'h00000000_FFFFFFFF);
        drain();
        check(last_h === 256'h82596786_4C9B994D_293AD69E_208B4537_2F45EB4E_A32BA7E1_E2147C32_8C5E8C50,
              "R8 known digest", last_h,
              256'h82596786_4C9B994D_293AD69E_208B4537_2F45EB4E_A32BA7E1_E2147C32_8C5E8C50);
        check(last_t === 64'd3, "R3 first block count", {192'd0, last_t}, 256'd3);

        // R3: carry from low into high counter word
        send({IVT[7], IVT[6], IVT[5], IVT[4], IVT[3], IVT[2], IVT[1], IVT[0]}, '0,
             64'h00000000_FFFFFFF0, 32'd64, 64'd0);
        drain();
        check(last_t === 64'h00000001_00000030, "R3 carry", {192'd0, last_t},
              {192'd0, 64'h00000001_00000030});

        // R5: chained two-block stream, counting bytes (byte k = k), final flag on block two
        for (int k = 0; k < 64; k++) mpat[8*k +: 8] = 8'(k);
        r1 = model({IVT[7], IVT[6], IVT[5], IVT[4], IVT[3], IVT[2], IVT[1], IVT[0]}, mpat,
                   64'd0, 32'd64, 64'd0);
        send({IVT[7], IVT[6], IVT[5], IVT[4], IVT[3], IVT[2], IVT[1], IVT[0]}, mpat, 64'd0, 32'd64, 64'd0);
        send(r1[255:0], ~mpat, r1[319:256], 32'd64, 64'h00000000_FFFFFFFF);
        drain();
        check(last_t === 64'd128, "R3 chained count", {192'd0, last_t}, 256'd128);

        // R2: input offered while busy is ignored
        send(256'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978_8796A5B4C3D2E1F0,
             {16{32'hA5A55A5A}}, 64'h12345678_9ABCDEF0, 32'd64, 64'hFFFFFFFF_FFFFFFFF);
        @(negedge clk);
        in_h = '1; in_msg = '1; in_t = '1; in_inc = 32'd7; in_f = '0; in_valid = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            if (in_ready !== 1'b0 || busy !== 1'b1) ok = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(ok, "R2 in_ready low while busy", 256'(ok), 256'd1);
        drain();

        // R10: stalled output holds, then releases
        out_ready = 1'b0;
        send(256'hDEADBEEF_00000000_11111111_22222222_33333333_44444444_55555555_66666666,
             {8{64'h0011223344556677}}, 64'h0, 32'd64, 64'd0);
        while (!out_valid) @(negedge clk);
        hold_h = out_h;
        ok = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (out_valid !== 1'b1 || out_h !== hold_h || in_ready !== 1'b0) ok = 1'b0;
        end
        check(ok, "R10 hold while stalled", out_h, hold_h);
        out_ready = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R10 release after handshake",
              256'({in_ready, out_valid}), 256'b10);
        drain();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule